// File: doc/BRIEF.md
# Digital I/O Register File with Change-of-State Interrupt

This block is the byte-wide register file of an eight-input, eight-output digital I/O port. A host reaches it over a simple synchronous interface: an address, a write strobe, a read strobe, write data and read data. A write lands on the rising clock edge at which the write strobe is high. Read data is combinational and is valid while the read strobe is high. Reading has no side effects.

The block holds four things:
- an eight-bit output latch with read-back;
- a buffer-disable bit;
- a change-of-state interrupt mask bit;
- a 32-bit watchdog timeout divisor that is written and read one byte at a time.

It also samples the eight input lines through a two-flop synchronizer. When the synchronized input word differs from its value one clock earlier, and the mask bit is clear, an interrupt latch sets. The latch drives an active-high interrupt output until the host clears it. There are two clear paths with different write rules. The watchdog counter that consumes the divisor lives outside this block.

Top module: `dio_regblock`

## Requirements
- R1: After reset the output latch, `dout`, `buf_dis`, `irq` and `wdog_div` are all 0. The mask reads 0x01 at offset 0x0B. Every other readable offset reads 0x00.
- R2: A write to offset 0x00 loads all eight bits of `dout` (1 = on) on that clock edge. A read of 0x00 returns the commanded byte.
- R3: A read of offset 0x01 returns `din` after two clock edges of synchronization: a change made before edge k is visible after edge k+1. Writes to 0x01 change nothing.
- R4: Bit 0 of a write to offset 0x0A sets `buf_dis` (1 = buffer disabled, 0 = enabled). Offset 0x0A reads back as {7'b0, buf_dis}.
- R5: Bit 0 of a write to offset 0x0B sets the change-of-state mask (1 = masked). Offset 0x0B reads back as {7'b0, mask}.
- R6: With the mask clear, an input change applied before edge k sets `irq` at edge k+2, and it stays set. With the mask set, an input change leaves `irq` unchanged.
- R7: A write of any data value to offset 0x0F clears `irq` on that edge.
- R8: A write of 0xFF to offset 0x29 clears `irq`, and a write of any other value there is ignored. A read of 0x29 returns {7'b0, irq}.
- R9: When a set and a clear of the interrupt latch fall in the same cycle, the set wins and `irq` is 1 afterwards.
- R10: Offsets 0x30..0x33 hold `wdog_div` little-endian: 0x30 holds bits 7:0 and 0x33 holds bits 31:24. Each byte is written alone and reads back.
- R11: Every offset other than 0x00, 0x01, 0x0A, 0x0B, 0x29 and 0x30..0x33 reads 0x00. Writes to those offsets, apart from the clear at 0x0F, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rdata` is 0 when it is low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| din | input | 8 | Raw input lines, asynchronous |
| dout | output | 8 | Output latch |
| buf_dis | output | 1 | Buffer disable, active high |
| irq | output | 1 | Change-of-state interrupt, active high |
| wdog_div | output | 32 | Watchdog timeout divisor |

## Verification
A wrong latch value shows at `dout`, `buf_dis`, `wdog_div` or `irq` one edge after the write that caused it. It also shows at once on a read of the matching offset. The bench therefore sweeps every output byte value and every divisor byte lane, and reads all 256 offsets after writing junk to the unmapped ones. A broken synchronizer or edge detector shows as `irq` rising one edge early or late. The bench checks the edge before and the edge at which `irq` must rise. It also checks the masked, cleared and set-beats-clear cases in their exact cycles.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int unsigned BYTE_W = 8;

  // register byte offsets; the watchdog lanes follow the base in order
  localparam logic [7:0] OFS_OUTLAT  = 8'h00;
  localparam logic [7:0] OFS_INPUTS  = 8'h01;
  localparam logic [7:0] OFS_BUFCTL  = 8'h0A;
  localparam logic [7:0] OFS_COSMSK  = 8'h0B;
  localparam logic [7:0] OFS_CLRANY  = 8'h0F;
  localparam logic [7:0] OFS_CLRSTAT = 8'h29;
  localparam logic [7:0] OFS_WDBASE  = 8'h30;

  localparam logic [7:0] CLR_KEY = 8'hFF;

  typedef struct packed {
    logic outlat;
    logic bufctl;
    logic cosmsk;
    logic clrany;
    logic clrstat;
  } wr_dec_t;
endpackage

// File: rtl/dio_insync.sv
module dio_insync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic             chg_o
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;
  logic [WIDTH-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = pin_i;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o = sync_q;
  assign chg_o = |(sync_q ^ prev_q);

  // the synchronized level is the raw input seen two edges earlier
  p_two_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> lvl_o == $past(pin_i, 2));
endmodule

// File: rtl/dio_irqlatch.sv
module dio_irqlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = set_i | clr_i;
    pend_d  = set_i;   // set beats clear when both are present
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign irq_o = pend_q;

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> irq_o);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !irq_o);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(irq_o));
endmodule

// File: rtl/dio_bytereg.sv
module dio_bytereg #(
  parameter int unsigned NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NBYTES-1:0]     we_i,
  input  logic [7:0]            wdata_i,
  output logic [NBYTES*8-1:0]   q_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [7:0] lane_q, lane_d;

    always_comb lane_d = wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lane_q <= '0;
      else if (we_i[g])  lane_q <= lane_d;
    end

    assign q_o[g*8 +: 8] = lane_q;

    p_lane_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i[g] |=> $stable(q_o[g*8 +: 8]));
    p_lane_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      we_i[g] |=> q_o[g*8 +: 8] == $past(wdata_i));
  end
endmodule

// File: rtl/dio_regblock.sv
module dio_regblock
  import dio_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NIO    = 8,
  parameter int unsigned WD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NIO-1:0]    din,
  output logic [NIO-1:0]    dout,
  output logic              buf_dis,
  output logic              irq,
  output logic [WD_W-1:0]   wdog_div
);
  localparam int unsigned WD_BYTES = WD_W / BYTE_W;

  // ---------------- write decode ----------------
  wr_dec_t           wdec;
  logic [WD_BYTES-1:0] wd_we;

  always_comb begin
    wdec.outlat  = wr_en && (addr == ADDR_W'(OFS_OUTLAT));
    wdec.bufctl  = wr_en && (addr == ADDR_W'(OFS_BUFCTL));
    wdec.cosmsk  = wr_en && (addr == ADDR_W'(OFS_COSMSK));
    wdec.clrany  = wr_en && (addr == ADDR_W'(OFS_CLRANY));
    wdec.clrstat = wr_en && (addr == ADDR_W'(OFS_CLRSTAT)) && (wdata == CLR_KEY);
  end

  for (genvar g = 0; g < WD_BYTES; g++) begin : g_wdec
    assign wd_we[g] = wr_en && (addr == ADDR_W'(OFS_WDBASE) + ADDR_W'(g));
  end

  // ---------------- control registers ----------------
  logic [NIO-1:0] out_q, out_d;
  logic           bd_q, bd_d;
  logic           msk_q, msk_d;
  logic           out_en, bd_en, msk_en;

  always_comb begin
    out_en = wdec.outlat;
    bd_en  = wdec.bufctl;
    msk_en = wdec.cosmsk;
    out_d  = wdata[NIO-1:0];
    bd_d   = wdata[0];
    msk_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      bd_q  <= 1'b0;
      msk_q <= 1'b1;
    end else begin
      if (out_en) out_q <= out_d;
      if (bd_en)  bd_q  <= bd_d;
      if (msk_en) msk_q <= msk_d;
    end
  end

  assign dout    = out_q;
  assign buf_dis = bd_q;

  // ---------------- inputs and interrupt ----------------
  logic [NIO-1:0] in_lvl;
  logic           in_chg;
  logic           irq_set, irq_clr;

  dio_insync #(.WIDTH(NIO)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (din),
    .lvl_o (in_lvl),
    .chg_o (in_chg)
  );

  assign irq_set = in_chg && !msk_q;
  assign irq_clr = wdec.clrany || wdec.clrstat;

  dio_irqlatch u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (irq_set),
    .clr_i (irq_clr),
    .irq_o (irq)
  );

  // ---------------- watchdog divisor ----------------
  dio_bytereg #(.NBYTES(WD_BYTES)) u_wdiv (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wd_we),
    .wdata_i (wdata),
    .q_o     (wdog_div)
  );

  // ---------------- read mux ----------------
  logic [7:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      ADDR_W'(OFS_OUTLAT):  rd_mux = 8'(out_q);
      ADDR_W'(OFS_INPUTS):  rd_mux = 8'(in_lvl);
      ADDR_W'(OFS_BUFCTL):  rd_mux = {7'b0, bd_q};
      ADDR_W'(OFS_COSMSK):  rd_mux = {7'b0, msk_q};
      ADDR_W'(OFS_CLRSTAT): rd_mux = {7'b0, irq};
      default: begin
        for (int i = 0; i < int'(WD_BYTES); i++)
          if (addr == ADDR_W'(OFS_WDBASE) + ADDR_W'(i))
            rd_mux = wdog_div[i*8 +: 8];
      end
    endcase
  end

  assign rdata = rd_en ? rd_mux : 8'h00;

  // ---------------- assertions ----------------
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(OFS_OUTLAT)) |=> $stable(dout));
  p_out_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_OUTLAT)) |=> dout == $past(wdata[NIO-1:0]));
  p_bufdis_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(OFS_BUFCTL)) |=> $stable(buf_dis));
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(in_chg && !msk_q));
  p_badkey_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && wr_en && addr == ADDR_W'(OFS_CLRSTAT) && wdata != CLR_KEY) |=> irq);
  p_status_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(OFS_CLRSTAT)) |-> rdata == {7'b0, irq});
  p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);
endmodule

// File: tb/sim_dio_regblock.sv
`timescale 1ns/1ps
module sim_dio_regblock;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en, rd_en;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        buf_dis, irq;
  logic [31:0] wdog_div;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic [7:0]  m_out, m_in;
  logic        m_bd, m_msk, m_irq;
  logic [31:0] m_wd;

  always #2.5 clk = ~clk;

  dio_regblock u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .din(din), .dout(dout),
    .buf_dis(buf_dis), .irq(irq), .wdog_div(wdog_div)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write: strobe held across exactly one rising edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // read now, without waiting for an edge
  task automatic rd_now(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #0.5;
    d = rdata;
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_out;
      8'h01: return m_in;
      8'h0A: return {7'b0, m_bd};
      8'h0B: return {7'b0, m_msk};
      8'h29: return {7'b0, m_irq};
      8'h30: return m_wd[7:0];
      8'h31: return m_wd[15:8];
      8'h32: return m_wd[23:16];
      8'h33: return m_wd[31:24];
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit mapped(input logic [7:0] a);
    return a == 8'h00 || a == 8'h01 || a == 8'h0A || a == 8'h0B || a == 8'h0F ||
           a == 8'h29 || (a >= 8'h30 && a <= 8'h33);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // input change then wait for the interrupt at the exact edge
  task automatic cos_event(input logic [7:0] v, input logic expect_set, input string req);
    @(negedge clk);
    din = v;
    repeat (2) @(negedge clk);
    chk({req, " irq not before second edge"}, irq, m_irq);
    @(negedge clk);
    if (expect_set) m_irq = 1'b1;
    chk({req, " irq at third edge"}, irq, m_irq);
    m_in = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0; din = '0;
    m_out = '0; m_in = '0; m_bd = 0; m_msk = 1; m_irq = 0; m_wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 dout", dout, 0);
    chk("R1 buf_dis", buf_dis, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wdog_div", wdog_div, 0);
    rd_now(8'h0B, r); chk("R1 mask reads 1", r, 1);
    rd_now(8'h00, r); chk("R1 out reads 0", r, 0);

    // R2 every output byte value
    for (int v = 0; v < 256; v++) begin
      wr(8'h00, 8'(v));
      m_out = 8'(v);
      chk("R2 dout", dout, m_out);
      rd_now(8'h00, r); chk("R2 readback", r, m_out);
    end

    // R3 input synchronizer latency and read-only behaviour
    @(negedge clk); din = 8'hA5;
    @(negedge clk); rd_now(8'h01, r); chk("R3 one edge old", r, 8'h00);
    @(negedge clk); rd_now(8'h01, r); chk("R3 two edges new", r, 8'hA5);
    m_in = 8'hA5;
    wr(8'h01, 8'h3C);
    rd_now(8'h01, r); chk("R3 write ignored", r, 8'hA5);
    chk("R6 masked change no irq", irq, 0);

    // R4 buffer disable, only bit 0 matters
    wr(8'h0A, 8'hFF); m_bd = 1;
    chk("R4 buf_dis set", buf_dis, 1);
    rd_now(8'h0A, r); chk("R4 readback", r, 1);
    wr(8'h0A, 8'hFE); m_bd = 0;
    chk("R4 buf_dis clear", buf_dis, 0);
    rd_now(8'h0A, r); chk("R4 readback 0", r, 0);

    // R6 masked: a change does not set irq
    cos_event(8'h5A, 1'b0, "R6 masked");

    // R5 unmask
    wr(8'h0B, 8'h00); m_msk = 0;
    rd_now(8'h0B, r); chk("R5 mask cleared", r, 0);

    // R6 and R7: each single bit toggles irq, any-value clear
    for (int b = 0; b < 8; b++) begin
      cos_event(m_in ^ 8'(1 << b), 1'b1, "R6 bit change");
      wr(8'h0F, 8'(b * 37)); m_irq = 0;
      chk("R7 clear any value", irq, 0);
    end

    // R8 wrong key ignored, 0xFF clears, status readback
    cos_event(m_in ^ 8'hFF, 1'b1, "R6 all bits");
    rd_now(8'h29, r); chk("R8 status set", r, 1);
    for (int k = 0; k < 255; k += 17) begin
      wr(8'h29, 8'(k));
      chk("R8 wrong key ignored", irq, 1);
    end
    wr(8'h29, 8'hFF); m_irq = 0;
    chk("R8 key clears", irq, 0);
    rd_now(8'h29, r); chk("R8 status clear", r, 0);

    // R9 set and clear in the same cycle
    @(negedge clk); din = m_in ^ 8'h81;
    @(negedge clk);
    @(negedge clk); addr = 8'h0F; wdata = 8'h00; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    m_in = m_in ^ 8'h81; m_irq = 1;
    chk("R9 set beats clear", irq, 1);
    wr(8'h0F, 8'h00); m_irq = 0;

    // R5 re-mask: change leaves irq clear
    wr(8'h0B, 8'h03); m_msk = 1;
    rd_now(8'h0B, r); chk("R5 mask readback", r, 1);
    cos_event(m_in ^ 8'h10, 1'b0, "R5 masked");

    // R10 each lane, little-endian
    for (int lane = 0; lane < 4; lane++) begin
      for (int v = 1; v < 256; v += 51) begin
        wr(8'(8'h30 + lane), 8'(v ^ (lane * 16)));
        m_wd[lane*8 +: 8] = 8'(v ^ (lane * 16));
        chk("R10 wdog_div", wdog_div, m_wd);
        rd_now(8'(8'h30 + lane), r); chk("R10 lane readback", r, m_wd[lane*8 +: 8]);
      end
    end

    // R11 junk to every unmapped offset, then full read sweep
    for (int a = 0; a < 256; a++)
      if (!mapped(8'(a))) wr(8'(a), 8'h5A);
    chk("R11 dout untouched", dout, m_out);
    chk("R11 wdog untouched", wdog_div, m_wd);
    chk("R11 irq untouched", irq, m_irq);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      rd_now(8'(a), r);
      chk("R11 read sweep", r, exp_rd(8'(a)));
    end

    summary();
    $finish;
  end
endmodule